// File: doc/BRIEF.md
# Seconds-Counter Alarm with Power-State Wake Request

This block watches a free-running seconds count and raises an alarm when that count reaches a programmed target. The target is a 32-bit value. Software writes it as two 16-bit halves through a small write port. A write is refused while the time-keeping domain reports that it is still synchronising. The comparison runs only on the cycle that carries the once-per-second tick, and only while the alarm enable input is high. Each matching second therefore produces exactly one alarm event.

An alarm event sets an interrupt. The interrupt stays high until software pulses a write-one-to-clear input. The event also looks at the power state the chip is in when the match is found. It pulses a wake request out of sleep, or a power-on request out of off. It issues no request while the chip is active. The sequencer that acts on these requests lies outside the block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the stored alarm time reads 0, and `irq`, `wake_req` and `on_req` are all low.
- R2: A write (`alm_wr_en` high, `sync_busy` low) loads `alm_wr_data` into one half of the alarm time at the next clock edge. Select 0 addresses bits 15:0 and select 1 addresses bits 31:16. The other half keeps its value.
- R3: A write attempted while `sync_busy` is high leaves the alarm time unchanged.
- R4: If `alarm_en` is high and `time_now` equals the alarm time on a cycle with `sec_tick` high, `irq` rises on the second clock edge after the edge that samples the tick.
- R5: Without a tick, with `alarm_en` low, or with unequal values, no alarm event occurs.
- R6: `irq` stays high until a cycle with `irq_clr` high, and it is low after the next edge. If a new alarm event lands on that same edge, the set wins and `irq` stays high.
- R7: An alarm event with `pwr_state` = 2'b01 (sleep) at the tick gives a one-cycle `wake_req` pulse, in the same cycle that the event sets `irq`.
- R8: An alarm event with `pwr_state` = 2'b00 (off) at the tick gives a one-cycle `on_req` pulse, in the same cycle that the event sets `irq`.
- R9: An alarm event with `pwr_state` = 2'b10 (active) or 2'b11 still sets `irq` but pulses neither request.
- R10: Driving `alarm_en` low does not clear an `irq` that is already set.
- R11: `wake_req` and `on_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse marking a new second |
| time_now | input | 32 | Current seconds count |
| alarm_en | input | 1 | Alarm enable |
| alm_wr_en | input | 1 | Alarm half-word write strobe |
| alm_wr_sel | input | 1 | Half select: 0 low, 1 high |
| alm_wr_data | input | 16 | Half-word write data |
| sync_busy | input | 1 | Time-keeping domain busy; refuses writes |
| pwr_state | input | 2 | Power state: 00 off, 01 sleep, 10 active, 11 other |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| irq | output | 1 | Latched alarm interrupt |
| wake_req | output | 1 | One-cycle wake request |
| on_req | output | 1 | One-cycle power-on request |
| alm_value | output | 32 | Stored alarm time |

## Verification
The assertions assume that `sec_tick` never stays high for two cycles in a row. Consecutive ticks would let one matching second fire twice, and both the pulse-width and the two-cycle latency checks rely on ticks being spaced apart. The assertions also assume that `pwr_state` and `alarm_en` hold steady across the tick cycle. The stimulus changes power state and enable only between tick sequences, drops each tick after a single cycle, and leaves several idle cycles before the next one. Writes are issued outside tick windows, so the compared target never changes during a tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   typedef enum logic [1:0] {
      PWR_OFF    = 2'b00,
      PWR_SLEEP  = 2'b01,
      PWR_ACTIVE = 2'b10,
      PWR_OTHER  = 2'b11
   } pwr_state_e;

endpackage

// File: rtl/alarm_time_regs.sv
module alarm_time_regs #(
   parameter int TIME_W = 32,
   parameter int HALF_W = 16,
   localparam int NUM_HALVES = TIME_W / HALF_W,
   localparam int SEL_W = $clog2(NUM_HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              busy,
   output logic [TIME_W-1:0] alarm_time
);

   logic wr_ok;
   assign wr_ok = wr_en && !busy;

   for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
      logic [HALF_W-1:0] half_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= '0;
         end else if (wr_ok && (wr_sel == SEL_W'(g))) begin
            half_q <= wr_data;
         end
      end
      assign alarm_time[g*HALF_W +: HALF_W] = half_q;
   end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int TIME_W = 32,
   parameter bit REG_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              enable,
   input  logic [TIME_W-1:0] time_now,
   input  logic [TIME_W-1:0] alarm_time,
   input  pwr_state_e        state_in,
   output logic              hit,
   output pwr_state_e        hit_state
);

   logic hit_now;
   assign hit_now = sec_tick && enable && (time_now == alarm_time);

   if (REG_CMP) begin : g_reg
      logic       hit_q;
      pwr_state_e st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
            st_q  <= PWR_ACTIVE;
         end else begin
            hit_q <= hit_now;
            st_q  <= state_in;
         end
      end
      assign hit       = hit_q;
      assign hit_state = st_q;
   end else begin : g_comb
      assign hit       = hit_now;
      assign hit_state = state_in;
   end

endmodule

// File: rtl/alarm_event.sv
module alarm_event
   import rtc_alarm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  pwr_state_e hit_state,
   input  logic       irq_clr,
   output logic       irq,
   output logic       wake_req,
   output logic       on_req
);

   logic irq_q, wake_q, on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         wake_q <= 1'b0;
         on_q   <= 1'b0;
      end else begin
         if (hit) begin
            irq_q <= 1'b1;
         end else if (irq_clr) begin
            irq_q <= 1'b0;
         end
         wake_q <= hit && (hit_state == PWR_SLEEP);
         on_q   <= hit && (hit_state == PWR_OFF);
      end
   end

   assign irq      = irq_q;
   assign wake_req = wake_q;
   assign on_req   = on_q;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int TIME_W = 32,
   parameter int HALF_W = 16,
   parameter bit REG_CMP = 1'b1,
   localparam int SEL_W = $clog2(TIME_W / HALF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [TIME_W-1:0] time_now,
   input  logic              alarm_en,
   input  logic              alm_wr_en,
   input  logic [SEL_W-1:0]  alm_wr_sel,
   input  logic [HALF_W-1:0] alm_wr_data,
   input  logic              sync_busy,
   input  logic [1:0]        pwr_state,
   input  logic              irq_clr,
   output logic              irq,
   output logic              wake_req,
   output logic              on_req,
   output logic [TIME_W-1:0] alm_value
);

   if (TIME_W % HALF_W != 0) begin : g_bad_split
      $error("TIME_W must be a whole multiple of HALF_W");
   end
   if (TIME_W / HALF_W < 2) begin : g_bad_halves
      $error("alarm time needs at least two write halves");
   end

   logic [TIME_W-1:0] alarm_time;
   logic              hit;
   pwr_state_e        hit_state;

   alarm_time_regs #(
      .TIME_W (TIME_W),
      .HALF_W (HALF_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (alm_wr_en),
      .wr_sel     (alm_wr_sel),
      .wr_data    (alm_wr_data),
      .busy       (sync_busy),
      .alarm_time (alarm_time)
   );

   alarm_match #(
      .TIME_W  (TIME_W),
      .REG_CMP (REG_CMP)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_tick   (sec_tick),
      .enable     (alarm_en),
      .time_now   (time_now),
      .alarm_time (alarm_time),
      .state_in   (pwr_state_e'(pwr_state)),
      .hit        (hit),
      .hit_state  (hit_state)
   );

   alarm_event u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .hit_state (hit_state),
      .irq_clr   (irq_clr),
      .irq       (irq),
      .wake_req  (wake_req),
      .on_req    (on_req)
   );

   assign alm_value = alarm_time;

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int TIME_W = 32,
   parameter int HALF_W = 16,
   parameter bit REG_CMP = 1'b1,
   localparam int SEL_W = $clog2(TIME_W / HALF_W),
   localparam int LAT = REG_CMP ? 2 : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              alarm_en,
   input logic              alm_wr_en,
   input logic [SEL_W-1:0]  alm_wr_sel,
   input logic [HALF_W-1:0] alm_wr_data,
   input logic              sync_busy,
   input logic [1:0]        pwr_state,
   input logic              irq_clr,
   input logic              irq,
   input logic              wake_req,
   input logic              on_req,
   input logic [TIME_W-1:0] alm_value
);

   a_r2_low_half_load: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_wr_en && !sync_busy && alm_wr_sel == '0)
      |=> (alm_value[HALF_W-1:0] == $past(alm_wr_data)));

   a_r2_high_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_wr_en && !sync_busy && alm_wr_sel == '0)
      |=> $stable(alm_value[TIME_W-1:HALF_W]));

   a_r3_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_wr_en && sync_busy) |=> $stable(alm_value));

   a_r4_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(sec_tick, LAT) && $past(alarm_en, LAT)));

   a_r6_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   a_r10_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(irq_clr));

   a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (irq && $past(pwr_state, LAT) == 2'b01));

   a_r8_on_from_off: assert property (@(posedge clk) disable iff (!rst_n)
      on_req |-> (irq && $past(pwr_state, LAT) == 2'b00));

   a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   a_r8_on_single: assert property (@(posedge clk) disable iff (!rst_n)
      on_req |=> !on_req);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_req && on_req));

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
   .TIME_W  (TIME_W),
   .HALF_W  (HALF_W),
   .REG_CMP (REG_CMP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_tick    (sec_tick),
   .alarm_en    (alarm_en),
   .alm_wr_en   (alm_wr_en),
   .alm_wr_sel  (alm_wr_sel),
   .alm_wr_data (alm_wr_data),
   .sync_busy   (sync_busy),
   .pwr_state   (pwr_state),
   .irq_clr     (irq_clr),
   .irq         (irq),
   .wake_req    (wake_req),
   .on_req      (on_req),
   .alm_value   (alm_value)
);

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [31:0] time_now = '0;
   logic        alarm_en = 1'b0;
   logic        alm_wr_en = 1'b0;
   logic        alm_wr_sel = 1'b0;
   logic [15:0] alm_wr_data = '0;
   logic        sync_busy = 1'b0;
   logic [1:0]  pwr_state = 2'b10;
   logic        irq_clr = 1'b0;
   logic        irq, wake_req, on_req;
   logic [31:0] alm_value;

   int unsigned cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] alm_m = '0;
   logic        irq_m = 1'b0;

   int unsigned q_at[$];
   logic [2:0]  q_val[$];
   string       q_tag[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_alarm_match u_rtc_alarm_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_tick    (sec_tick),
      .time_now    (time_now),
      .alarm_en    (alarm_en),
      .alm_wr_en   (alm_wr_en),
      .alm_wr_sel  (alm_wr_sel),
      .alm_wr_data (alm_wr_data),
      .sync_busy   (sync_busy),
      .pwr_state   (pwr_state),
      .irq_clr     (irq_clr),
      .irq         (irq),
      .wake_req    (wake_req),
      .on_req      (on_req),
      .alm_value   (alm_value)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items when their cycle arrives
   always @(negedge clk) begin
      if (q_at.size() > 0 && q_at[0] == cyc) begin
         logic [2:0] e;
         string      t;
         void'(q_at.pop_front());
         e = q_val.pop_front();
         t = q_tag.pop_front();
         check({irq, wake_req, on_req} == e, t,
               32'({irq, wake_req, on_req}), 32'(e));
      end
   end

   task automatic tick(input logic [31:0] t, input string tag);
      logic m;
      @(negedge clk);
      time_now = t;
      sec_tick = 1'b1;
      m = alarm_en && (t == alm_m);
      if (m) irq_m = 1'b1;
      q_at.push_back(cyc + 2);
      q_val.push_back({irq_m, m && pwr_state == 2'b01, m && pwr_state == 2'b00});
      q_tag.push_back(tag);
      q_at.push_back(cyc + 3);
      q_val.push_back({irq_m, 2'b00});
      q_tag.push_back(tag);
      @(negedge clk);
      sec_tick = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [15:0] d, input logic busy,
                     input string tag);
      @(negedge clk);
      alm_wr_en = 1'b1;
      alm_wr_sel = sel;
      alm_wr_data = d;
      sync_busy = busy;
      @(negedge clk);
      alm_wr_en = 1'b0;
      sync_busy = 1'b0;
      if (!busy) begin
         if (sel) alm_m[31:16] = d;
         else alm_m[15:0] = d;
      end
      check(alm_value == alm_m, tag, alm_value, alm_m);
   endtask

   task automatic clear_irq(input string tag);
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      irq_m = 1'b0;
      check(irq == 1'b0, tag, 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({irq, wake_req, on_req} == 3'b000, "R1 outputs after reset",
            32'({irq, wake_req, on_req}), 32'd0);
      check(alm_value == 32'd0, "R1 alarm after reset", alm_value, 32'd0);

      wr(1'b0, 16'h1234, 1'b0, "R2 low half write");
      wr(1'b1, 16'hABCD, 1'b0, "R2 high half write keeps low");
      wr(1'b0, 16'h1234, 1'b0, "R2 low half rewrite keeps high");

      pwr_state = 2'b01;
      tick(32'hABCD1234, "R5 disabled match ignored");
      alarm_en = 1'b1;
      tick(32'hABCD1233, "R5 unequal value ignored");

      // no tick while values are equal
      @(negedge clk);
      time_now = 32'hABCD1234;
      repeat (4) @(negedge clk);
      check(irq == 1'b0, "R5 no tick no event", 32'(irq), 32'd0);

      tick(32'hABCD1234, "R4 R7 sleep match wakes");
      repeat (5) @(negedge clk);
      check(irq == 1'b1, "R6 interrupt held", 32'(irq), 32'd1);
      clear_irq("R6 clear");

      pwr_state = 2'b00;
      tick(32'hABCD1234, "R8 off match powers on");
      clear_irq("R6 clear after off");

      pwr_state = 2'b10;
      tick(32'hABCD1234, "R9 active match no request");
      clear_irq("R6 clear after active");
      pwr_state = 2'b11;
      tick(32'hABCD1234, "R9 other state no request");

      // R10: disabling keeps a latched interrupt
      @(negedge clk);
      alarm_en = 1'b0;
      repeat (4) @(negedge clk);
      check(irq == 1'b1, "R10 disable keeps irq", 32'(irq), 32'd1);
      clear_irq("R10 clear after disable");
      pwr_state = 2'b01;
      tick(32'hABCD1234, "R10 disabled match suppressed");

      // R3: busy write refused
      wr(1'b0, 16'h5555, 1'b1, "R3 busy write refused");
      alarm_en = 1'b1;
      tick(32'hABCD5555, "R3 refused value does not match");
      tick(32'hABCD1234, "R3 old value still matches");

      // R6: set wins over a clear on the same edge
      pwr_state = 2'b10;
      @(negedge clk);
      time_now = 32'hABCD1234;
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(irq == 1'b1, "R6 set wins over clear", 32'(irq), 32'd1);
      irq_m = 1'b1;
      check({wake_req, on_req} == 2'b00, "R11 R9 no request active",
            32'({wake_req, on_req}), 32'd0);
      clear_irq("R6 final clear");

      repeat (3) @(negedge clk);
      check(q_at.size() == 0, "R4 scoreboard drained", q_at.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule